// File: doc/BRIEF.md
# Crossbar Memory Switch with Per-Column Arbitration

This block connects a set of processor ports to a set of memory modules through a full crossbar. Every processor–module pair has a crosspoint that is either open or closed. Each memory module owns one column of crosspoints, and that column's logic decides which processor, if any, is connected to the module. Columns work independently of each other. Processors aimed at different modules are served in the same cycles, and processors aimed at the same module take turns.

A processor starts an access by raising its request together with a write flag, an address and write data. The upper address bits name the target module and the lower bits name a word inside it. The column that wins the processor drives one enable cycle into its module and then returns a single-cycle acknowledge. For a read, the acknowledge carries the read data. The processor keeps its request, address and data steady until it sees the acknowledge. It then lowers the request for at least one cycle before it starts another access. Each module is a plain synchronous RAM that returns read data one cycle after its enable.

Top module: `xbar_switch`

## Requirements
- R1: After the synchronous active-high reset, no acknowledge and no module enable is high. In every column, processor 0 has the highest priority for the first grant.
- R2: Address bits [ADDR_W-1:WORD_W] choose the target module (module j when they equal j). Bits [WORD_W-1:0] appear unchanged on that module's word address during its enable cycle.
- R3: Within a column at most one crosspoint is closed at a time. No processor ever gets an acknowledge from two columns at once, and a column never acknowledges two processors in the same cycle.
- R4: A grant produces exactly one enable cycle on the module. During that cycle the module sees the granted processor's write flag and, for a write, its write data.
- R5: Processors that target different modules are served in parallel. When four processors each start an access to a distinct idle module in the same cycle, all four acknowledges rise together.
- R6: When several processors compete for one column, the grant goes round-robin, beginning with the index after the processor granted last in that column. A processor that keeps requesting therefore waits at most N_PROC-1 other grants.
- R7: Suppose a column is idle and a request for it is sampled at clock edge k. The module enable is then high in the cycle after edge k. The acknowledge is high for exactly the one cycle that follows edge k+2. The column takes part in arbitration again from the cycle after the acknowledge.
- R8: A read's acknowledge comes with the word most recently written to that module location. A write stores its data at the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_req | input | N_PROC | Access request, one per processor |
| p_we | input | N_PROC | Write flag per processor (1 = write, 0 = read) |
| p_addr | input | N_PROC*ADDR_W | Packed processor addresses, processor i at bits [i*ADDR_W +: ADDR_W] |
| p_wdata | input | N_PROC*DATA_W | Packed processor write data |
| p_ack | output | N_PROC | One-cycle completion acknowledge per processor |
| p_rdata | output | N_PROC*DATA_W | Packed read data, valid while the matching acknowledge is high |
| m_en | output | N_MEM | Module access enable, one per module |
| m_we | output | N_MEM | Module write enable |
| m_addr | output | N_MEM*WORD_W | Packed word addresses into each module |
| m_wdata | output | N_MEM*DATA_W | Packed write data into each module |
| m_rdata | input | N_MEM*DATA_W | Packed module read data, valid the cycle after the enable |

## Verification
A corrupted column state would show at the ports within one or two cycles. It could appear as an enable that repeats or is missing, or as an acknowledge at the wrong distance from the enable. It could also go to the wrong processor or reach two processors from the same column. A stale or corrupted round-robin pointer shows up on the next contended grant, because the order in which the waiting processors are acknowledged changes. A wrong word mux or module decode surfaces on the first read-back of a written location as a data mismatch. The bench's behavioural model predicts every enable and acknowledge cycle by cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Phases of one column's access cycle
  typedef enum logic [1:0] {
    COL_IDLE   = 2'd0,  // crosspoints open, arbitrating
    COL_ACCESS = 2'd1,  // module enable cycle
    COL_RESP   = 2'd2,  // module read data returning
    COL_HOLD   = 2'd3   // acknowledge cycle, path released after it
  } col_state_e;

endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N_PROC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PROC-1:0] req,
  input  logic              take,
  output logic [N_PROC-1:0] gnt
);

  localparam int IDX_W = (N_PROC > 1) ? $clog2(N_PROC) : 1;

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] win;
  logic [IDX_W-1:0] cand;
  logic             hit;

  // Search starts one past the last winner and wraps around
  always_comb begin
    gnt  = '0;
    win  = last_q;
    hit  = 1'b0;
    cand = '0;
    for (int k = 1; k <= N_PROC; k++) begin
      cand = IDX_W'((int'(last_q) + k) % N_PROC);
      if (!hit && req[cand]) begin
        gnt[cand] = 1'b1;
        win       = cand;
        hit       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IDX_W'(N_PROC - 1);
    end else if (take && hit) begin
      last_q <= win;
    end
  end

  AST_GNT_WITHIN_REQ: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~req) == '0)); // R6
  AST_GNT_WORK_CONSERVING: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> $onehot(gnt)); // R6

endmodule

// File: rtl/xbar_target_dec.sv
module xbar_target_dec #(
  parameter int N_PROC = 4,
  parameter int N_MEM  = 4,
  parameter int MSEL_W = 2
) (
  input  logic [N_PROC-1:0]        p_req,
  input  logic [N_PROC*MSEL_W-1:0] p_sel,
  output logic [N_MEM*N_PROC-1:0]  col_req
);

  // col_req[j*N_PROC + i]: processor i is requesting module j
  for (genvar j = 0; j < N_MEM; j++) begin : g_col
    for (genvar i = 0; i < N_PROC; i++) begin : g_proc
      assign col_req[j*N_PROC + i] =
        p_req[i] && (p_sel[i*MSEL_W +: MSEL_W] == MSEL_W'(j));
    end
  end

endmodule

// File: rtl/xbar_column.sv
module xbar_column #(
  parameter int N_PROC = 4,
  parameter int WORD_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_PROC-1:0]        col_req,
  input  logic [N_PROC-1:0]        p_we,
  input  logic [N_PROC*WORD_W-1:0] p_word,
  input  logic [N_PROC*DATA_W-1:0] p_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [WORD_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [N_PROC-1:0]        ack_vec,
  output logic [DATA_W-1:0]        rsp_data
);

  import xbar_pkg::*;

  col_state_e          st_q;
  logic [N_PROC-1:0]   gnt;
  logic [N_PROC-1:0]   xp_q;      // closed crosspoints of this column
  logic                take;
  logic                sel_we;
  logic [WORD_W-1:0]   sel_word;
  logic [DATA_W-1:0]   sel_wdata;

  assign take = (st_q == COL_IDLE) && (|col_req);

  xbar_rr_arb #(
    .N_PROC (N_PROC)
  ) u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (col_req),
    .take (take),
    .gnt  (gnt)
  );

  // One-hot AND-OR path selection of the winning processor
  always_comb begin
    sel_we    = 1'b0;
    sel_word  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N_PROC; i++) begin
      sel_we    = sel_we | (p_we[i] & gnt[i]);
      sel_word  = sel_word  | (p_word[i*WORD_W +: WORD_W]   & {WORD_W{gnt[i]}});
      sel_wdata = sel_wdata | (p_wdata[i*DATA_W +: DATA_W] & {DATA_W{gnt[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= COL_IDLE;
      xp_q      <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ack_vec   <= '0;
      rsp_data  <= '0;
    end else begin
      unique case (st_q)
        COL_IDLE: begin
          if (take) begin
            xp_q      <= gnt;
            mem_en    <= 1'b1;
            mem_we    <= sel_we;
            mem_addr  <= sel_word;
            mem_wdata <= sel_wdata;
            st_q      <= COL_ACCESS;
          end
        end
        COL_ACCESS: begin
          mem_en <= 1'b0;
          st_q   <= COL_RESP;
        end
        COL_RESP: begin
          ack_vec <= xp_q;
          if (!mem_we) begin
            rsp_data <= mem_rdata;
          end
          st_q <= COL_HOLD;
        end
        COL_HOLD: begin
          ack_vec <= '0;
          xp_q    <= '0;
          st_q    <= COL_IDLE;
        end
        default: st_q <= COL_IDLE;
      endcase
    end
  end

  AST_XP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(xp_q)); // R3
  AST_ACK_TO_OWNER: assert property (@(posedge clk) disable iff (rst)
    (|ack_vec) |-> (ack_vec == xp_q)); // R3
  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en); // R4
  AST_EN_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> $onehot(xp_q)); // R4
  AST_ACK_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> ##1 (|ack_vec)); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|ack_vec) |=> (ack_vec == '0)); // R7

endmodule

// File: rtl/xbar_resp_merge.sv
module xbar_resp_merge #(
  parameter int N_PROC = 4,
  parameter int N_MEM  = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_MEM*N_PROC-1:0]  ack_all,
  input  logic [N_MEM*DATA_W-1:0]  rdata_all,
  output logic [N_PROC-1:0]        p_ack,
  output logic [N_PROC*DATA_W-1:0] p_rdata
);

  for (genvar i = 0; i < N_PROC; i++) begin : g_proc
    logic [N_MEM-1:0]  src;
    logic [DATA_W-1:0] acc;

    always_comb begin
      acc = '0;
      for (int j = 0; j < N_MEM; j++) begin
        src[j] = ack_all[j*N_PROC + i];
        acc    = acc | (rdata_all[j*DATA_W +: DATA_W] & {DATA_W{src[j]}});
      end
    end

    assign p_ack[i]                   = |src;
    assign p_rdata[i*DATA_W +: DATA_W] = acc;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(src)); // R3
  end

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int N_PROC = 4,
  parameter int N_MEM  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PROC-1:0]         p_req,
  input  logic [N_PROC-1:0]         p_we,
  input  logic [N_PROC*ADDR_W-1:0]  p_addr,
  input  logic [N_PROC*DATA_W-1:0]  p_wdata,
  output logic [N_PROC-1:0]         p_ack,
  output logic [N_PROC*DATA_W-1:0]  p_rdata,
  output logic [N_MEM-1:0]          m_en,
  output logic [N_MEM-1:0]          m_we,
  output logic [N_MEM*(ADDR_W-$clog2(N_MEM))-1:0] m_addr,
  output logic [N_MEM*DATA_W-1:0]   m_wdata,
  input  logic [N_MEM*DATA_W-1:0]   m_rdata
);

  localparam int MSEL_W = $clog2(N_MEM);
  localparam int WORD_W = ADDR_W - MSEL_W;

  logic [N_PROC*MSEL_W-1:0] p_sel;
  logic [N_PROC*WORD_W-1:0] p_word;
  logic [N_MEM*N_PROC-1:0]  col_req;
  logic [N_MEM*N_PROC-1:0]  ack_all;
  logic [N_MEM*DATA_W-1:0]  rdata_all;

  // Split each address into module select and word index
  for (genvar i = 0; i < N_PROC; i++) begin : g_split
    assign p_sel[i*MSEL_W +: MSEL_W]  = p_addr[i*ADDR_W + WORD_W +: MSEL_W];
    assign p_word[i*WORD_W +: WORD_W] = p_addr[i*ADDR_W +: WORD_W];
  end

  xbar_target_dec #(
    .N_PROC (N_PROC),
    .N_MEM  (N_MEM),
    .MSEL_W (MSEL_W)
  ) u_dec (
    .p_req   (p_req),
    .p_sel   (p_sel),
    .col_req (col_req)
  );

  for (genvar j = 0; j < N_MEM; j++) begin : g_col
    xbar_column #(
      .N_PROC (N_PROC),
      .WORD_W (WORD_W),
      .DATA_W (DATA_W)
    ) u_col (
      .clk       (clk),
      .rst       (rst),
      .col_req   (col_req[j*N_PROC +: N_PROC]),
      .p_we      (p_we),
      .p_word    (p_word),
      .p_wdata   (p_wdata),
      .mem_rdata (m_rdata[j*DATA_W +: DATA_W]),
      .mem_en    (m_en[j]),
      .mem_we    (m_we[j]),
      .mem_addr  (m_addr[j*WORD_W +: WORD_W]),
      .mem_wdata (m_wdata[j*DATA_W +: DATA_W]),
      .ack_vec   (ack_all[j*N_PROC +: N_PROC]),
      .rsp_data  (rdata_all[j*DATA_W +: DATA_W])
    );
  end

  xbar_resp_merge #(
    .N_PROC (N_PROC),
    .N_MEM  (N_MEM),
    .DATA_W (DATA_W)
  ) u_merge (
    .clk       (clk),
    .rst       (rst),
    .ack_all   (ack_all),
    .rdata_all (rdata_all),
    .p_ack     (p_ack),
    .p_rdata   (p_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> ((p_ack == '0) && (m_en == '0))); // R1

endmodule

// File: tb/xbar_switch_tb.sv
module xbar_switch_tb;

  localparam int NP = 4;
  localparam int NM = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int MW = 2;
  localparam int WW = AW - MW;
  localparam int NW = 1 << WW;
  localparam int MAXOP = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NP-1:0]    p_req = '0;
  logic [NP-1:0]    p_we = '0;
  logic [NP*AW-1:0] p_addr = '0;
  logic [NP*DW-1:0] p_wdata = '0;
  logic [NP-1:0]    p_ack;
  logic [NP*DW-1:0] p_rdata;
  logic [NM-1:0]    m_en, m_we;
  logic [NM*WW-1:0] m_addr;
  logic [NM*DW-1:0] m_wdata;
  logic [NM*DW-1:0] m_rdata;

  xbar_switch #(.N_PROC(NP), .N_MEM(NM), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .p_req(p_req), .p_we(p_we), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata), .m_en(m_en),
    .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata));

  // Synchronous RAM modules of the environment
  logic [DW-1:0] ram [NM][NW];
  logic [DW-1:0] ram_q [NM];
  always @(posedge clk) begin
    for (int j = 0; j < NM; j++) begin
      if (rst) begin
        for (int w = 0; w < NW; w++) ram[j][w] <= '0;
        ram_q[j] <= '0;
      end else if (m_en[j]) begin
        if (m_we[j]) ram[j][m_addr[j*WW +: WW]] <= m_wdata[j*DW +: DW];
        else         ram_q[j] <= ram[j][m_addr[j*WW +: WW]];
      end
    end
  end
  always_comb for (int j = 0; j < NM; j++) m_rdata[j*DW +: DW] = ram_q[j];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // Scripted operations per processor
  bit            op_we   [NP][MAXOP];
  logic [AW-1:0] op_addr [NP][MAXOP];
  logic [DW-1:0] op_dat  [NP][MAXOP];
  int n_ops [NP];
  int idx   [NP];
  bit pend  [NP];

  task automatic add_op(input int p, input bit we, input int addr, input int dat);
    op_we[p][n_ops[p]]   = we;
    op_addr[p][n_ops[p]] = AW'(addr);
    op_dat[p][n_ops[p]]  = DW'(dat);
    n_ops[p]++;
  endtask

  // Reference model state
  int            st_m   [NM];   // 0 idle, 1 enable, 2 data return, 3 acknowledge
  int            own_m  [NM];
  int            last_m [NM];
  bit            rd_m_op[NM];
  logic [DW-1:0] rd_m   [NM];
  logic [DW-1:0] shadow [NM][NW];

  // Acknowledge logs per column, all-four-together count
  int ord_c [NM][64];
  int n_ord [NM];
  int all4 = 0;

  initial begin
    for (int i = 0; i < NP; i++) begin n_ops[i] = 0; idx[i] = 0; pend[i] = 0; end
    for (int j = 0; j < NM; j++) n_ord[j] = 0;
  end

  always @(negedge clk) begin
    if (rst) begin
      for (int j = 0; j < NM; j++) begin
        st_m[j] = 0; own_m[j] = 0; last_m[j] = NP - 1; rd_m_op[j] = 0; rd_m[j] = '0;
        for (int w = 0; w < NW; w++) shadow[j][w] = '0;
      end
      for (int i = 0; i < NP; i++) begin pend[i] = 0; p_req[i] = 1'b0; end
    end else begin
      int n_ack;
      int per_col [NM];
      n_ack = 0;
      for (int j = 0; j < NM; j++) per_col[j] = 0;
      // compare outputs with the model
      for (int i = 0; i < NP; i++) begin
        bit exp_ack;
        int jj;
        exp_ack = 0; jj = 0;
        for (int j = 0; j < NM; j++)
          if (st_m[j] == 3 && own_m[j] == i) begin exp_ack = 1; jj = j; end
        chk(p_ack[i] == exp_ack, "R7 ack timing", p_ack[i], exp_ack);
        if (exp_ack && rd_m_op[jj])
          chk(p_rdata[i*DW +: DW] == rd_m[jj], "R8 read data", p_rdata[i*DW +: DW], rd_m[jj]);
        if (p_ack[i]) begin
          int c;
          c = int'(p_addr[i*AW + WW +: MW]);
          n_ack++;
          per_col[c]++;
          if (n_ord[c] < 64) begin ord_c[c][n_ord[c]] = i; n_ord[c]++; end
        end
      end
      for (int j = 0; j < NM; j++) begin
        if (per_col[j] > 1) chk(0, "R3 two acks from one column", per_col[j], 1);
        chk(m_en[j] == (st_m[j] == 1), "R4 enable", m_en[j], st_m[j] == 1);
        if (st_m[j] == 1) begin
          int o;
          o = own_m[j];
          chk(m_addr[j*WW +: WW] == p_addr[o*AW +: WW], "R2 word address",
              m_addr[j*WW +: WW], p_addr[o*AW +: WW]);
          chk(m_we[j] == p_we[o], "R4 write flag", m_we[j], p_we[o]);
          if (p_we[o])
            chk(m_wdata[j*DW +: DW] == p_wdata[o*DW +: DW], "R4 write data",
                m_wdata[j*DW +: DW], p_wdata[o*DW +: DW]);
        end
      end
      if (n_ack == NP) all4++;
      // processor agents
      for (int i = 0; i < NP; i++) begin
        if (pend[i] && p_ack[i]) begin
          pend[i] = 0; p_req[i] = 1'b0; idx[i]++;
        end else if (!pend[i] && idx[i] < n_ops[i]) begin
          pend[i] = 1;
          p_req[i] = 1'b1;
          p_we[i] = op_we[i][idx[i]];
          p_addr[i*AW +: AW] = op_addr[i][idx[i]];
          p_wdata[i*DW +: DW] = op_dat[i][idx[i]];
        end
      end
      // advance the model with the inputs seen at the next edge
      for (int j = 0; j < NM; j++) begin
        case (st_m[j])
          0: begin
            bit found;
            found = 0;
            for (int k = 1; k <= NP; k++) begin
              int c;
              c = (last_m[j] + k) % NP;
              if (!found && p_req[c] && int'(p_addr[c*AW + WW +: MW]) == j) begin
                found = 1; own_m[j] = c; last_m[j] = c; st_m[j] = 1;
              end
            end
          end
          1: begin
            int o;
            o = own_m[j];
            rd_m_op[j] = !p_we[o];
            if (p_we[o]) shadow[j][p_addr[o*AW +: WW]] = p_wdata[o*DW +: DW];
            else         rd_m[j] = shadow[j][p_addr[o*AW +: WW]];
            st_m[j] = 2;
          end
          2: st_m[j] = 3;
          default: st_m[j] = 0;
        endcase
      end
    end
  end

  task automatic wait_idle();
    bit busy;
    do begin
      @(posedge clk);
      busy = 0;
      for (int i = 0; i < NP; i++) if (pend[i] || idx[i] < n_ops[i]) busy = 1;
    end while (busy);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int s, a4;
    logic [15:0] lfsr;
    int exp_ord [8];
    repeat (3) @(posedge clk);
    #1;
    chk(p_ack == '0, "R1 ack in reset", p_ack, 0);
    chk(m_en == '0, "R1 enable in reset", m_en, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(p_ack == '0, "R1 ack after reset", p_ack, 0);
    chk(m_en == '0, "R1 enable after reset", m_en, 0);
    @(posedge clk);
    #1;

    // Reset priority: processors 1 and 0 contend for module 3
    s = n_ord[3];
    add_op(1, 1, 'hC2, 'hA001);
    add_op(0, 1, 'hC1, 'hA000);
    wait_idle();
    chk(ord_c[3][s] == 0, "R1 first grant", ord_c[3][s], 0);
    chk(ord_c[3][s+1] == 1, "R1 second grant", ord_c[3][s+1], 1);

    // Parallel accesses to distinct modules
    a4 = all4;
    for (int i = 0; i < NP; i++) begin
      add_op(i, 1, (i << WW) | 5, 'h1000 + i);
      add_op(i, 0, (i << WW) | 5, 0);
    end
    wait_idle();
    chk(all4 - a4 == 2, "R5 simultaneous acks", all4 - a4, 2);

    // Round-robin under full contention on module 2 (last winner there: 2)
    s = n_ord[2];
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < NP; i++) add_op(i, 0, (2 << WW) | i, 0);
    wait_idle();
    exp_ord = '{3, 0, 1, 2, 3, 0, 1, 2};
    for (int k = 0; k < 8; k++)
      chk(ord_c[2][s+k] == exp_ord[k], "R6 grant order", ord_c[2][s+k], exp_ord[k]);

    // Mixed traffic with pseudo-random data, then read-back
    lfsr = 16'hACE1;
    for (int i = 0; i < NP; i++)
      for (int k = 0; k < 6; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        add_op(i, 1, (((i + k) % NM) << WW) | ((11 * k + 7 * i) % NW), lfsr);
      end
    for (int i = 0; i < NP; i++)
      for (int k = 0; k < 6; k++)
        add_op(i, 0, (((i + k) % NM) << WW) | ((11 * k + 7 * i) % NW), 0);
    wait_idle();

    // Top word of the top module, written by one processor, read by another
    add_op(3, 1, 'hFF, 'hBEEF);
    wait_idle();
    add_op(0, 0, 'hFF, 0);
    wait_idle();
    chk(ram[3][NW-1] == 16'hBEEF, "R8 stored word", ram[3][NW-1], 'hBEEF);
    chk(ram[1][5] == 16'h1001, "R2 module select", ram[1][5], 'h1001);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung, expected completion");
      summary();
      $finish;
    end
  end

endmodule